// File: doc/BRIEF.md
# External Bus Write Cycle Sequencer

This block turns a single processor-side write request into the strobe sequence of one write access on an external asynchronous memory or peripheral bus. It runs from a clock at twice the bus interface rate, so one cycle of the fast clock is half an interface period. Every output comes straight from a flop. Chip select and address lead the write strobe by half an interface period. Data is turned on half a period after the strobe falls. Chip select then lags the strobe release by half a period.

Each request carries its own stretch settings. The low time of the strobe can be lengthened by a wait-state count, by an external acknowledge input that holds the access until the target releases it, or by both together. A per-access hold flag keeps the data driven for one more interface period after the strobe rises. The acknowledge input is asynchronous and passes through a two-flop synchronizer first. After the synchronized acknowledge is seen high, the strobe stays low for a fixed two further interface periods.

Top module: `ext_write_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `bus_cs_n` and `bus_we_n` are 1 and `bus_data_oe` is 0.
- R2: A request is taken only in a cycle where `req` is 1 and `busy` is 0. Address, data, wait count, mode and hold flag are captured then. A `req` pulse while `busy` is 1 starts no further access.
- R3: `bus_cs_n` falls and `bus_addr` shows the captured address exactly one clock before `bus_we_n` falls. `bus_addr` stays stable while `bus_cs_n` is low.
- R4: In mode 2'b00 (wait count only), `bus_we_n` stays low for 2 + 2*W clocks, where W is the 4-bit wait count.
- R5: `bus_data_oe` rises one clock after `bus_we_n` falls, with `bus_data` equal to the captured data.
- R6: In mode 2'b01 (acknowledge only), the wait count is ignored. With `ack_in` held high, `bus_we_n` stays low for 6 clocks.
- R7: In mode 2'b10 (wait count plus acknowledge), with `ack_in` held high, `bus_we_n` stays low for 2 + 2*W + 4 clocks.
- R8: In an acknowledge mode, a low `ack_in` holds `bus_we_n` low. When `ack_in` rises between clock edges, `bus_we_n` rises on the seventh rising edge after that point: two edges of synchronizer and four clocks of completion are included.
- R9: With hold flag 0, `bus_data_oe` falls together with the rise of `bus_we_n`. With hold flag 1, `bus_data_oe` falls 2 clocks after that rise. `bus_cs_n` rises 1 + 2*hold clocks after `bus_we_n` rises.
- R10: `busy` falls one clock after `bus_cs_n` rises. At least 2 clocks always pass between a rise of `bus_we_n` and its next fall.
- R11: Mode 2'b11 behaves the same as mode 2'b10.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus interface rate |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Write request, taken when busy is low |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_wait | input | WAIT_W | Wait-state count, in interface periods |
| req_mode | input | 2 | Stretch mode: 00 wait, 01 ack, 10/11 wait plus ack |
| req_hold | input | 1 | Extra data hold of one interface period |
| busy | output | 1 | An access is in progress |
| ack_in | input | 1 | Asynchronous acknowledge, low means stall |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_data | output | DW | Bus write data |
| bus_data_oe | output | 1 | Data driver enable |

## Verification
The hardest case is a stall in which the acknowledge is released at a known point. The release has to arrive after the wait count has run out, so that the sequencer is already sitting in its stall state and the full synchronizer latency shows up on the strobe. The bench holds `ack_in` low from before the request. It then raises `ack_in` at a negedge chosen a random number of clocks past the end of the programmed stretch, and checks that `bus_we_n` rises exactly seven edges later. A one-cycle `req` pulse is also placed inside each busy window to show that it is ignored.

// File: rtl/wr_seq_pkg.sv
package wr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_ACKWAIT,
    ST_TAIL,
    ST_POST,
    ST_REL
  } wr_state_e;

  localparam logic [1:0] MODE_WAIT = 2'b00;
  localparam logic [1:0] MODE_ACK  = 2'b01;

  // completion after acknowledge release: two interface periods
  localparam int TAIL_CLKS = 4;

endpackage

// File: rtl/wr_ack_sync.sv
module wr_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], din};
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/wr_seq_capture.sv
module wr_seq_capture #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/wr_seq_fsm.sv
module wr_seq_fsm
  import wr_seq_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [WAIT_W-1:0] req_wait,
  input  logic [1:0]        req_mode,
  input  logic              req_hold,
  input  logic              ack_s,
  output logic              accept,
  output logic              busy,
  output logic              cs_n,
  output logic              we_n,
  output logic              data_oe
);
  localparam int CNT_W = WAIT_W + 2;
  localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_CLKS - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(2);

  wr_state_e        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ack_en_q, hold_q;
  logic [CNT_W-1:0] base_m1;
  logic [CNT_W-1:0] post_load;

  assign accept    = (st_q == ST_IDLE) && req;
  assign base_m1   = (req_mode == MODE_ACK) ? CNT_W'(1) : CNT_W'({req_wait, 1'b1});
  assign post_load = hold_q ? HOLD_LOAD : '0;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_IDLE: if (req) begin
        st_n  = ST_SETUP;
        cnt_n = base_m1;
      end
      ST_SETUP: st_n = ST_STROBE;
      ST_STROBE: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (!ack_en_q) begin
          st_n  = ST_POST;
          cnt_n = post_load;
        end else if (ack_s) begin
          st_n  = ST_TAIL;
          cnt_n = TAIL_LOAD;
        end else begin
          st_n = ST_ACKWAIT;
        end
      end
      ST_ACKWAIT: if (ack_s) begin
        st_n  = ST_TAIL;
        cnt_n = TAIL_LOAD;
      end
      ST_TAIL: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else begin
          st_n  = ST_POST;
          cnt_n = post_load;
        end
      end
      ST_POST: begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else             st_n  = ST_REL;
      end
      ST_REL:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      ack_en_q <= 1'b0;
      hold_q   <= 1'b0;
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      we_n     <= 1'b1;
      data_oe  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      if (accept) begin
        ack_en_q <= (req_mode != MODE_WAIT);
        hold_q   <= req_hold;
      end
      busy    <= (st_n != ST_IDLE);
      cs_n    <= !(st_n inside {ST_SETUP, ST_STROBE, ST_ACKWAIT, ST_TAIL, ST_POST});
      we_n    <= !(st_n inside {ST_STROBE, ST_ACKWAIT, ST_TAIL});
      data_oe <= ((st_n == ST_STROBE) && (st_q != ST_SETUP)) ||
                 (st_n == ST_ACKWAIT) || (st_n == ST_TAIL) ||
                 ((st_n == ST_POST) && (cnt_n != '0));
    end
  end
endmodule

// File: rtl/ext_write_seq.sv
module ext_write_seq #(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int WAIT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic [WAIT_W-1:0] req_wait,
  input  logic [1:0]        req_mode,
  input  logic              req_hold,
  output logic              busy,
  input  logic              ack_in,
  output logic              bus_cs_n,
  output logic              bus_we_n,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_data,
  output logic              bus_data_oe
);
  logic ack_s;
  logic accept;

  wr_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (ack_in),
    .dout(ack_s)
  );

  wr_seq_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .req_wait(req_wait),
    .req_mode(req_mode),
    .req_hold(req_hold),
    .ack_s   (ack_s),
    .accept  (accept),
    .busy    (busy),
    .cs_n    (bus_cs_n),
    .we_n    (bus_we_n),
    .data_oe (bus_data_oe)
  );

  wr_seq_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .addr_in(req_addr),
    .data_in(req_data),
    .addr_q (bus_addr),
    .data_q (bus_data)
  );
endmodule

// File: rtl/ext_write_seq_chk.sv
module ext_write_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          bus_cs_n,
  input logic          bus_we_n,
  input logic          bus_data_oe,
  input logic [AW-1:0] bus_addr
);
  localparam int GAP_MIN = 2;
  logic [1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                      gap_q <= 2'(GAP_MIN);
    else if (!bus_we_n)           gap_q <= '0;
    else if (gap_q < 2'(GAP_MIN)) gap_q <= gap_q + 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bus_cs_n && bus_we_n && !bus_data_oe));

  // R3
  cs_leads_we_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_we_n) |-> $past(!bus_cs_n));

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

  // R5
  oe_after_we_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_data_oe) |-> (!bus_we_n && $past(!bus_we_n)));

  // R9
  cs_lags_we_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> $past(bus_we_n));

  // R10
  busy_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bus_cs_n && $past(bus_cs_n)));

  // R10
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_we_n) |-> (gap_q == 2'(GAP_MIN)));
endmodule

bind ext_write_seq ext_write_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .bus_cs_n   (bus_cs_n),
  .bus_we_n   (bus_we_n),
  .bus_data_oe(bus_data_oe),
  .bus_addr   (bus_addr)
);

// File: tb/sim_ext_write_seq.sv
`timescale 1ns/1ps
module sim_ext_write_seq;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [WAIT_W-1:0] req_wait = '0;
  logic [1:0] req_mode = '0;
  logic req_hold = 1'b0;
  logic ack_in = 1'b0;
  logic busy, bus_cs_n, bus_we_n, bus_data_oe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_write_seq #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_data(req_data),
    .req_wait(req_wait), .req_mode(req_mode), .req_hold(req_hold), .busy(busy),
    .ack_in(ack_in), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_data_oe(bus_data_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // strobe low length before any acknowledge handling
  function automatic int base_len(input int w, input int mode);
    return (mode == 1) ? 2 : 2 + 2 * w;
  endfunction

  // ackcase: 0 ack held high, 1 stall then release
  task automatic do_write(input int a, input int d, input int w, input int mode,
                          input int hold, input int ackcase, input int extra);
    int t, we_fall, oe_rise, we_rise, oe_fall, cs_rise, busy_fall, raise_t, exp_rise;
    int data_seen, addr_seen;
    bit ack_stall;
    ack_stall = (mode != 0) && (ackcase == 1);
    ack_in = !ack_stall;
    repeat (4) @(negedge clk);
    raise_t = base_len(w, mode) + 2 + extra;
    req = 1'b1; req_addr = AW'(a); req_data = DW'(d);
    req_wait = WAIT_W'(w); req_mode = 2'(mode); req_hold = hold[0];
    @(negedge clk);
    req = 1'b0; req_addr = ~req_addr; req_data = ~req_data;
    // R3: chip select and address lead the strobe by one clock
    chk(!bus_cs_n && bus_we_n && busy, "R3 setup phase", {bus_cs_n, bus_we_n}, 1);
    chk(bus_addr == AW'(a), "R3 address at setup", int'(bus_addr), a);
    we_fall = -1; oe_rise = -1; we_rise = -1; oe_fall = -1; cs_rise = -1; busy_fall = -1;
    data_seen = 0; addr_seen = 0;
    t = 0;
    while (busy_fall < 0 && t < 400) begin
      @(negedge clk);
      t++;
      if (t == 1) req = 1'b1;   // R2: request while busy must be ignored
      if (t == 2) req = 1'b0;
      if (we_fall < 0 && !bus_we_n) we_fall = t;
      if (oe_rise < 0 && bus_data_oe) begin
        oe_rise = t; data_seen = int'(bus_data); addr_seen = int'(bus_addr);
      end
      if (we_fall > 0 && we_rise < 0 && bus_we_n) we_rise = t;
      if (oe_rise > 0 && oe_fall < 0 && !bus_data_oe) oe_fall = t;
      if (we_fall > 0 && cs_rise < 0 && bus_cs_n) cs_rise = t;
      if (busy_fall < 0 && !busy) busy_fall = t;
      if (ack_stall && t == raise_t) begin
        chk(!bus_we_n, "R8 strobe held while ack low", bus_we_n, 0);
        ack_in = 1'b1;
      end
    end
    if (mode == 0)       exp_rise = 1 + base_len(w, mode);
    else if (!ack_stall) exp_rise = 1 + base_len(w, mode) + 4;
    else                 exp_rise = raise_t + 7;
    chk(we_fall == 1, "R3 strobe fall", we_fall, 1);
    chk(oe_rise == 2, "R5 data enable", oe_rise, 2);
    chk(data_seen == d, "R5 data value", data_seen, d);
    chk(addr_seen == a, "R2 captured address", addr_seen, a);
    if (mode == 0)      chk(we_rise == exp_rise, "R4 wait-only width", we_rise, exp_rise);
    else if (ack_stall) chk(we_rise == exp_rise, "R8 ack release latency", we_rise, exp_rise);
    else if (mode == 1) chk(we_rise == exp_rise, "R6 ack-only width", we_rise, exp_rise);
    else if (mode == 2) chk(we_rise == exp_rise, "R7 combined width", we_rise, exp_rise);
    else                chk(we_rise == exp_rise, "R11 mode 3 width", we_rise, exp_rise);
    chk(oe_fall == we_rise + 2 * hold, "R9 data release", oe_fall, we_rise + 2 * hold);
    chk(cs_rise == we_rise + 1 + 2 * hold, "R9 chip select release", cs_rise, we_rise + 1 + 2 * hold);
    chk(busy_fall == cs_rise + 1, "R10 busy release", busy_fall, cs_rise + 1);
    repeat (6) @(negedge clk);
    chk(bus_cs_n && !busy, "R2 no second access", {bus_cs_n, busy}, 2);
    ack_in = 1'b0;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_cs_n && bus_we_n && !bus_data_oe && !busy, "R1 reset state",
        {bus_cs_n, bus_we_n, bus_data_oe, busy}, 12);
    do_write(16'h1234, 16'hA5A5, 0, 0, 0, 0, 0);
    do_write(16'hFFFF, 16'h0001, 15, 0, 1, 0, 0);
    do_write(16'h0101, 16'h7E7E, 9, 1, 0, 0, 0);
    do_write(16'h0202, 16'h3C3C, 3, 2, 1, 0, 0);
    do_write(16'h0303, 16'hC3C3, 2, 3, 0, 0, 0);
    do_write(16'h0404, 16'h5555, 0, 1, 1, 1, 0);
    do_write(16'h0505, 16'hAAAA, 5, 2, 0, 1, 3);
    for (int i = 0; i < 30; i++) begin
      do_write(int'($urandom_range(16'hFFFF)), int'($urandom_range(16'hFFFF)),
               int'($urandom_range(15)), int'($urandom_range(3)),
               int'($urandom_range(1)), int'($urandom_range(1)),
               int'($urandom_range(6)));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule